// File: doc/BRIEF.md
# Flash Word-Program Sequencer

This block is a host-side controller that carries out a single word program on a parallel NOR-style flash and then reports the result. A pulse on `start` captures a target address and data word. The block then asks an external flash bus driver for a sequence of bus cycles:

1. a write of the program-setup command 40h;
2. a write of the data word to the target address;
3. repeated status reads until the ready bit comes back set;
4. a clear-status command 50h whenever the outcome is not clean;
5. in every case, a read-array command FFh as the last cycle.

The bus driver is assumed to exist. It takes a held request and answers with a one-cycle acknowledge. For a read, the status byte arrives on the low eight bits of `bus_rdata` together with the acknowledge.

The status byte is interpreted with the following fields:

| Status bit | Meaning when set |
|---|---|
| bit 7 | operation finished (ready) |
| bit 5 | command-sequence error |
| bit 4 | write error |
| bit 3 | programming-supply error |

The block waits a fixed number of idle cycles between polls and gives up after a fixed number of polls. It finishes with a one-cycle `done` pulse and a 3-bit result code. The error flags in the flash stay set until cleared, and a set supply flag blocks later writes. The sequencer therefore always clears them before it hands the flash back in array-read mode.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `bus_req` and `err_code` are all 0.
- R2: A `start` pulse in idle captures `req_addr` and `req_data`. The first bus cycle is then a write (`bus_we`=1) of 40h to the captured address, and the second is a write of the captured data to the same address.
- R3: After the data cycle the block issues status reads (`bus_we`=0). A read whose bit 7 is 0 is followed by exactly POLL_GAP cycles with `bus_req` low and then another read. The error bits in such a not-ready read are ignored.
- R4: On the first read with bit 7 set, the result code is taken from bits {5,4,3} of the status byte. Bit 5 set gives code 4. Otherwise bits 4 and 3 both set give code 3, bit 4 alone gives code 2, bit 3 alone gives code 1, and neither gives code 0 (success).
- R5: A nonzero result code is followed by a write of 50h and then a write of FFh. A zero code is followed by a write of FFh only. There are no idle cycles between these writes, and FFh is always the final bus cycle.
- R6: If MAX_POLLS consecutive reads all return bit 7 = 0, the result code is 7, and the clear (50h) and read-array (FFh) writes follow.
- R7: `busy` is high from the cycle after `start` until the final cycle ends. `done` is then high for exactly one cycle, during which `err_code` shows the result code.
- R8: A `start` pulse while `busy` is high has no effect: no extra bus cycle and no change of address or data in the running sequence.
- R9: Once raised, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one program operation (one-cycle pulse) |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Word to program |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 supply, 2 write, 3 write+supply, 4 sequence/combined, 7 timeout |
| bus_req | output | 1 | Bus cycle request to the flash driver |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | DATA_W | Bus write data (command or data word) |
| bus_ack | input | 1 | Driver acknowledge, one cycle per bus cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack`; status byte in bits 7:0 |

## Verification
The bench sweeps every combination of the three error bits in the final status byte against busy spans of zero up to beyond the poll limit. This separates each decode branch, and also separates a clean finish from the timeout path.

Not-ready reads carry all three error bits set. A sequencer that decodes before the ready bit is seen therefore shows up as a wrong code. The bench logs every bus cycle with its preceding idle count, which distinguishes the poll spacing, the presence or absence of the clear command, and an extra cycle caused by a stray `start` pulsed in the middle of every run.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_DATA  = 3'd2,
    ST_POLL  = 3'd3,
    ST_GAP   = 3'd4,
    ST_CLEAR = 3'd5,
    ST_ARRAY = 3'd6,
    ST_DONE  = 3'd7
  } seq_state_e;

  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

  localparam logic [2:0] RC_OK       = 3'd0;
  localparam logic [2:0] RC_SUPPLY   = 3'd1;
  localparam logic [2:0] RC_WRITE    = 3'd2;
  localparam logic [2:0] RC_WR_SUPP  = 3'd3;
  localparam logic [2:0] RC_SEQUENCE = 3'd4;
  localparam logic [2:0] RC_TIMEOUT  = 3'd7;

  localparam int STB_READY = 7;
  localparam int STB_SEQ   = 5;
  localparam int STB_WRITE = 4;
  localparam int STB_SUPP  = 3;

endpackage

// File: rtl/fps_status_decode.sv
module fps_status_decode
  import fps_pkg::*;
(
  input  logic [7:0] status,
  output logic       st_ready,
  output logic [2:0] st_code
);

  logic unused_status_bits;
  assign unused_status_bits = ^{status[6], status[2:0]};

  assign st_ready = status[STB_READY];

  // Sequence flag dominates; the supply flag is examined before the write flag.
  always_comb begin
    if (status[STB_SEQ]) begin
      st_code = RC_SEQUENCE;
    end else if (status[STB_SUPP]) begin
      st_code = status[STB_WRITE] ? RC_WR_SUPP : RC_SUPPLY;
    end else if (status[STB_WRITE]) begin
      st_code = RC_WRITE;
    end else begin
      st_code = RC_OK;
    end
  end

endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
  parameter int MAX_POLLS = 1024,
  parameter int POLL_GAP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_clr,
  input  logic poll_inc,
  input  logic gap_load,
  input  logic gap_run,
  output logic last_poll,
  output logic gap_zero
);

  localparam int PCNT_W = $clog2(MAX_POLLS) + 1;
  localparam int GCNT_W = $clog2(POLL_GAP) + 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(MAX_POLLS - 1);
  localparam logic [GCNT_W-1:0] GCNT_INIT = GCNT_W'(POLL_GAP - 1);

  logic [PCNT_W-1:0] poll_cnt_q, poll_cnt_d;
  logic              poll_en;
  logic [GCNT_W-1:0] gap_cnt_q, gap_cnt_d;
  logic              gap_en;

  assign last_poll = (poll_cnt_q == PCNT_LAST);
  assign gap_zero  = (gap_cnt_q == '0);

  always_comb begin
    poll_en    = tmr_clr | poll_inc;
    poll_cnt_d = tmr_clr ? '0 : poll_cnt_q + 1'b1;
  end

  always_comb begin
    gap_en    = gap_load | (gap_run & ~gap_zero);
    gap_cnt_d = gap_load ? GCNT_INIT : gap_cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt_q <= '0;
    end else if (poll_en) begin
      poll_cnt_q <= poll_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt_q <= '0;
    end else if (gap_en) begin
      gap_cnt_q <= gap_cnt_d;
    end
  end

  // R6: poll count never passes the last permitted poll
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(poll_cnt_q) < MAX_POLLS);

  // R3: idle spacing counter stays within the configured gap
  p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_cnt_q) < POLL_GAP);

  // R3: a load starts a fresh countdown from the top
  p_gap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_load |=> (gap_cnt_q == GCNT_INIT));

endmodule

// File: rtl/fps_fsm.sv
module fps_fsm
  import fps_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              bus_ack,
  input  logic              st_ready,
  input  logic [2:0]        st_code,
  input  logic              last_poll,
  input  logic              gap_zero,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              tmr_clr,
  output logic              poll_inc,
  output logic              gap_load,
  output logic              gap_run
);

  localparam int PAD_W = DATA_W - 8;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              req_en;
  logic [2:0]        code_q, code_d;
  logic              code_en;

  always_comb begin
    state_d  = state_q;
    req_en   = 1'b0;
    code_en  = 1'b0;
    code_d   = code_q;
    tmr_clr  = 1'b0;
    poll_inc = 1'b0;
    gap_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          req_en  = 1'b1;
          tmr_clr = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: if (bus_ack) state_d = ST_DATA;
      ST_DATA:  if (bus_ack) state_d = ST_POLL;
      ST_POLL: begin
        if (bus_ack) begin
          if (st_ready) begin
            code_en = 1'b1;
            code_d  = st_code;
            state_d = (st_code != RC_OK) ? ST_CLEAR : ST_ARRAY;
          end else if (last_poll) begin
            code_en = 1'b1;
            code_d  = RC_TIMEOUT;
            state_d = ST_CLEAR;
          end else begin
            poll_inc = 1'b1;
            gap_load = 1'b1;
            state_d  = ST_GAP;
          end
        end
      end
      ST_GAP:   if (gap_zero) state_d = ST_POLL;
      ST_CLEAR: if (bus_ack) state_d = ST_ARRAY;
      ST_ARRAY: if (bus_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (req_en) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RC_OK;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b1;
    bus_wdata = '0;
    case (state_q)
      ST_SETUP: begin bus_req = 1'b1; bus_wdata = {{PAD_W{1'b0}}, CMD_PROG_SETUP}; end
      ST_DATA:  begin bus_req = 1'b1; bus_wdata = data_q; end
      ST_POLL:  begin bus_req = 1'b1; bus_we = 1'b0; end
      ST_CLEAR: begin bus_req = 1'b1; bus_wdata = {{PAD_W{1'b0}}, CMD_CLR_STATUS}; end
      ST_ARRAY: begin bus_req = 1'b1; bus_wdata = {{PAD_W{1'b0}}, CMD_READ_ARRAY}; end
      default:  ;
    endcase
  end

  assign bus_addr = addr_q;
  assign gap_run  = (state_q == ST_GAP);
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done     = (state_q == ST_DONE);
  assign err_code = code_q;

  // R9: an unacknowledged request keeps its whole cycle description
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start during a running sequence leaves the captured target alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_q) && $stable(data_q)));

  // R6: an exhausted poll budget ends with the timeout code
  p_timeout_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && bus_ack && !st_ready && last_poll) |=> (err_code == RC_TIMEOUT));

  // R5: any failing result routes through the clear command before read-array
  p_clear_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL && bus_ack && st_ready && st_code != RC_OK) |=> (bus_req && bus_wdata[7:0] == CMD_CLR_STATUS));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 1024,
  parameter int POLL_GAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic       st_ready;
  logic [2:0] st_code;
  logic       last_poll, gap_zero;
  logic       tmr_clr, poll_inc, gap_load, gap_run;

  generate
    if (DATA_W > 8) begin : g_wide
      logic unused_rdata_hi;
      assign unused_rdata_hi = ^bus_rdata[DATA_W-1:8];
    end
  endgenerate

  fps_status_decode u_decode (
    .status   (bus_rdata[7:0]),
    .st_ready (st_ready),
    .st_code  (st_code)
  );

  fps_poll_timer #(
    .MAX_POLLS (MAX_POLLS),
    .POLL_GAP  (POLL_GAP)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_clr   (tmr_clr),
    .poll_inc  (poll_inc),
    .gap_load  (gap_load),
    .gap_run   (gap_run),
    .last_poll (last_poll),
    .gap_zero  (gap_zero)
  );

  fps_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .bus_ack   (bus_ack),
    .st_ready  (st_ready),
    .st_code   (st_code),
    .last_poll (last_poll),
    .gap_zero  (gap_zero),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tmr_clr   (tmr_clr),
    .poll_inc  (poll_inc),
    .gap_load  (gap_load),
    .gap_run   (gap_run)
  );

  // R1: nothing is requested or reported while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !bus_req);

  // R7: busy only rises in response to a start pulse
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int MAXP = 4;
  localparam int GAP  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          busy, done;
  logic [2:0]    err_code;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack;
  logic [DW-1:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  // model controls, driven only from the initial block
  logic     model_clr = 1'b0;
  int       busy_polls = 0;
  logic [2:0] sr_bits = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(
    .ADDR_W (AW), .DATA_W (DW), .MAX_POLLS (MAXP), .POLL_GAP (GAP)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .req_addr (req_addr), .req_data (req_data),
    .busy (busy), .done (done), .err_code (err_code),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_ack (bus_ack), .bus_rdata (bus_rdata)
  );

  // flash driver + device model: ack one cycle after request
  int rd_seen;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      rd_seen   <= 0;
    end else begin
      bus_ack <= bus_req & ~bus_ack;
      if (model_clr) begin
        rd_seen <= 0;
      end else if (bus_req && !bus_ack && !bus_we) begin
        if (rd_seen < busy_polls) bus_rdata <= 16'h0038;
        else bus_rdata <= 16'h0080 | (16'(sr_bits) << 3);
        rd_seen <= rd_seen + 1;
      end
    end
  end

  // bus monitor
  logic          t_we   [16];
  logic [AW-1:0] t_addr [16];
  logic [DW-1:0] t_data [16];
  int            t_idle [16];
  int t_n, idle_run, done_n, hold_bad;
  logic          p_we;
  logic [AW-1:0] p_a;
  logic [DW-1:0] p_d;

  always @(negedge clk) begin
    if (model_clr) begin
      t_n = 0; idle_run = 0; done_n = 0; hold_bad = 0;
    end else begin
      if (done) done_n++;
      if (bus_req && !bus_ack) begin
        p_we = bus_we; p_a = bus_addr; p_d = bus_wdata;
      end
      if (bus_req && bus_ack) begin
        if (bus_we !== p_we || bus_addr !== p_a || bus_wdata !== p_d) hold_bad++;
        if (t_n < 16) begin
          t_we[t_n] = bus_we; t_addr[t_n] = bus_addr;
          t_data[t_n] = bus_wdata; t_idle[t_n] = idle_run;
        end
        t_n++;
        idle_run = 0;
      end else if (!bus_req && busy) begin
        idle_run++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int sr);
    if (sr[2]) return 4;
    if (sr[0]) return sr[1] ? 3 : 1;
    if (sr[1]) return 2;
    return 0;
  endfunction

  task automatic run_op(input int bp, input int sr);
    int idx = bp * 8 + sr;
    logic [AW-1:0] a = AW'(idx * 37 + 5);
    logic [DW-1:0] d = 16'hA500 ^ DW'(idx);
    int ec, nrd, k, wait_n;
    ec  = (bp >= MAXP) ? 7 : exp_code(sr);
    nrd = (bp >= MAXP) ? MAXP : bp + 1;
    @(negedge clk); #1;
    model_clr = 1'b1; busy_polls = bp; sr_bits = 3'(sr);
    @(negedge clk); #1;
    model_clr = 1'b0; start = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    #1 start = 1'b0; req_addr = ~a; req_data = ~d;
    @(negedge clk); @(negedge clk); #1;
    start = 1'b1;                       // R8 stray start while busy
    @(negedge clk); #1 start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 300) begin @(negedge clk); wait_n++; end
    chk(done == 1'b1, "R7 done reached", int'(done), 1);
    chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
    if (ec == 7) chk(err_code == 3'(ec), "R6 timeout code", int'(err_code), ec);
    else         chk(err_code == 3'(ec), "R4 result code", int'(err_code), ec);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single pulse", int'(done), 0);
    chk(done_n == 1, "R8 one completion only", done_n, 1);
    chk(hold_bad == 0, "R9 request held until ack", hold_bad, 0);
    chk(t_n == 2 + nrd + ((ec != 0) ? 2 : 1), "R8 bus cycle count", t_n, 2 + nrd + ((ec != 0) ? 2 : 1));
    if (t_n == 2 + nrd + ((ec != 0) ? 2 : 1)) begin
      for (int i = 0; i < t_n; i++)
        chk(t_addr[i] == a, "R2 cycle address", int'(t_addr[i]), int'(a));
      chk(t_we[0] && t_data[0] == 16'h0040 && t_idle[0] == 0, "R2 setup cycle", int'(t_data[0]), 64);
      chk(t_we[1] && t_data[1] == d && t_idle[1] == 0, "R2 data cycle", int'(t_data[1]), int'(d));
      for (k = 0; k < nrd; k++)
        chk(!t_we[2+k] && t_idle[2+k] == ((k == 0) ? 0 : GAP), "R3 status poll spacing",
            t_idle[2+k], (k == 0) ? 0 : GAP);
      k = 2 + nrd;
      if (ec != 0) begin
        chk(t_we[k] && t_data[k] == 16'h0050 && t_idle[k] == 0, "R5 clear command", int'(t_data[k]), 80);
        k++;
      end
      chk(t_we[k] && t_data[k] == 16'h00FF && t_idle[k] == 0, "R5 final read-array", int'(t_data[k]), 255);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && err_code == 3'd0, "R1 state during reset",
        int'({busy, done, bus_req}), 0);
    #1 rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!busy && !done && !bus_req && err_code == 3'd0, "R1 state after reset",
        int'({busy, done, bus_req, err_code}), 0);
    for (int bp = 0; bp <= MAXP + 1; bp++)
      for (int sr = 0; sr < 8; sr++)
        run_op(bp, sr);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule